// File: doc/BRIEF.md
# Clock Select and Divide Enable Generator

This block routes one of several source clock-enable pulse trains to a programmable divider and emits a slower enable pulse train. Everything runs on a single fast clock. Each source is a stream of single-cycle enable pulses, and the output is another such stream. No clock is ever gated or muxed. A consumer simply qualifies its registers with the output enable.

Two configuration words drive the block. A field of the select word picks the source. A field of the divider word sets the ratio, and a build-time mode decides how that field is read: field plus one, a power of two, twice the field plus one, or a fixed ratio that ignores the field. When a select index points past the populated inputs, the block falls back to input 0. Each write strobe loads its word. A write to either word restarts the division, so the first pulse under the new setting comes a full new period later.

Top module: `selDivClockEn`

## Requirements
- R1: During reset `outEn` is 0. After reset the configuration is taken from the reset parameters. The defaults give source 0 and linear field 1, so `outEn` fires once per 2 pulses of source 0.
- R2: In linear mode (`DIV_MODE` = DIV_LINEAR), `outEn` fires once per field+1 selected-source pulses. The divider field is `divReg[DIV_OFS +: DIV_W]` (defaults: bits 20:16, so ratios 1 to 32).
- R3: In shift mode (DIV_SHIFT), `outEn` fires once per 2^field selected-source pulses.
- R4: In doubled mode (DIV_DOUBLED), `outEn` fires once per 2×(field+1) selected-source pulses.
- R5: In constant mode (DIV_CONST), `outEn` fires once per `CONST_RATIO` pulses, and the divider field has no effect.
- R6: The select field is `selReg[SEL_OFS +: SEL_W]` (defaults: bits 10:8). An index k below `NUM_INPUTS` routes `srcEn[k]`. Pulses on any other source have no effect on `outEn`.
- R7: A select index at or above `NUM_INPUTS` routes `srcEn[0]`.
- R8: A cycle with `selWrite` or `divWrite` high clears the pulse count. The next `outEn` then needs a full N new pulses, with no short period.
- R9: A selected-source pulse in the same cycle as a configuration write is discarded, even when it would have completed the count.
- R10: `outEn` is high for exactly the one cycle that follows the clock edge sampling the Nth counted pulse. It is low again a cycle later unless another terminal pulse arrived.

Top module parameters (REG_W, NUM_INPUTS, SEL_OFS, SEL_W, DIV_OFS, DIV_W, DIV_MODE, CONST_RATIO, SEL_RST, DIV_RST) set widths, positions, mode and reset words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock shared by all enables |
| rstN | input | 1 | Active-low synchronous reset |
| srcEn | input | NUM_INPUTS | Source enable pulse trains, one bit per source |
| selReg | input | REG_W | Select configuration word |
| selWrite | input | 1 | Loads the select field from `selReg` |
| divReg | input | REG_W | Divider configuration word |
| divWrite | input | 1 | Loads the divider field from `divReg` |
| outEn | output | 1 | Divided single-cycle enable pulse |

## Verification
A configuration write and the terminal pulse of the count can land in the same cycle, and then the restart must win. The bench drives a selected-source pulse on the very edge that carries a divider write, with a ratio of 1, so that pulse alone would have produced an output. It judges that no `outEn` appears, and that the next lone pulse produces exactly one. Every divide mode is also run through one shared table of select and field values, including select indices that must fall back to input 0.

// File: rtl/selDivPkg.sv
package selDivPkg;

  typedef enum logic [1:0] {
    DIV_LINEAR  = 2'd0,
    DIV_SHIFT   = 2'd1,
    DIV_DOUBLED = 2'd2,
    DIV_CONST   = 2'd3
  } divModeE;

  // strobes from control to datapath
  typedef struct packed {
    logic selChange;
    logic divChange;
  } ctrlStrobesT;

endpackage

// File: rtl/selDivCtrl.sv
module selDivCtrl import selDivPkg::*; #(
  parameter int      REG_W       = 32,
  parameter int      NUM_INPUTS  = 5,
  parameter int      SEL_OFS     = 8,
  parameter int      SEL_W       = 3,
  parameter int      DIV_OFS     = 16,
  parameter int      DIV_W       = 5,
  parameter divModeE DIV_MODE    = DIV_LINEAR,
  parameter int      CONST_RATIO = 3,
  parameter logic [REG_W-1:0] SEL_RST = '0,
  parameter logic [REG_W-1:0] DIV_RST = '0,
  localparam int IDX_W = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1,
  localparam int CNT_W = 2 ** DIV_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  selReg,
  input  logic              selWrite,
  input  logic [REG_W-1:0]  divReg,
  input  logic              divWrite,
  output ctrlStrobesT       strobes,
  output logic [IDX_W-1:0]  selIdx,
  output logic [CNT_W-1:0]  term
);

  function automatic logic [IDX_W-1:0] decodeSel(input logic [SEL_W-1:0] f);
    if (int'(f) >= NUM_INPUTS) return '0;
    return IDX_W'(f);
  endfunction

  // terminal count = ratio - 1
  function automatic logic [CNT_W-1:0] termOf(input logic [DIV_W-1:0] f);
    case (DIV_MODE)
      DIV_LINEAR:  return CNT_W'(f);
      DIV_SHIFT:   return (CNT_W'(1) << f) - CNT_W'(1);
      DIV_DOUBLED: return (CNT_W'(f) << 1) + CNT_W'(1);
      default:     return CNT_W'(CONST_RATIO - 1);
    endcase
  endfunction

  logic [SEL_W-1:0] selField;
  logic [DIV_W-1:0] divField;
  logic [IDX_W-1:0] selIdxQ;
  logic [CNT_W-1:0] termQ;
  logic             unusedCfg;

  assign selField  = selReg[SEL_OFS +: SEL_W];
  assign divField  = divReg[DIV_OFS +: DIV_W];
  assign unusedCfg = ^{selReg, divReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIdxQ <= decodeSel(SEL_RST[SEL_OFS +: SEL_W]);
      termQ   <= termOf(DIV_RST[DIV_OFS +: DIV_W]);
    end else begin
      if (selWrite) selIdxQ <= decodeSel(selField);
      if (divWrite) termQ   <= termOf(divField);
    end
  end

  always_comb begin
    strobes.selChange = selWrite;
    strobes.divChange = divWrite;
  end

  assign selIdx = selIdxQ;
  assign term   = termQ;

  // R7: an out-of-range index loads input 0
  assert_sel_fallback_R7: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite && (int'(selField) >= NUM_INPUTS)) |=> (selIdx == '0));

  // R6: a populated index is routed unchanged
  assert_sel_direct_R6: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite && (int'(selField) < NUM_INPUTS)) |=> (int'(selIdx) == int'($past(selField))));

endmodule

// File: rtl/selDivPath.sv
module selDivPath import selDivPkg::*; #(
  parameter int NUM_INPUTS = 5,
  parameter int DIV_W      = 5,
  localparam int IDX_W = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1,
  localparam int CNT_W = 2 ** DIV_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_INPUTS-1:0] srcEn,
  input  ctrlStrobesT           strobes,
  input  logic [IDX_W-1:0]      selIdx,
  input  logic [CNT_W-1:0]      term,
  output logic                  outEn
);

  logic [NUM_INPUTS-1:0] hit;
  logic                  srcPulse;
  logic                  restart;
  logic [CNT_W-1:0]      cnt;
  logic                  outEnQ;

  generate
    for (genvar g = 0; g < NUM_INPUTS; g++) begin : gSrc
      assign hit[g] = srcEn[g] && (selIdx == IDX_W'(g));
    end
  endgenerate

  assign srcPulse = |hit;
  assign restart  = strobes.selChange | strobes.divChange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      outEnQ <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      outEnQ <= 1'b0;
    end else if (srcPulse) begin
      if (cnt >= term) begin
        cnt    <= '0;
        outEnQ <= 1'b1;
      end else begin
        cnt    <= cnt + CNT_W'(1);
        outEnQ <= 1'b0;
      end
    end else begin
      outEnQ <= 1'b0;
    end
  end

  assign outEn = outEnQ;

  // R2: count never passes the terminal value
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= term);

  // R8: a configuration write clears the count
  assert_restart_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (cnt == '0) && !outEn);

  // R10: an output pulse needs a counted source pulse one edge earlier
  assert_out_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> $past(srcPulse && !restart));

endmodule

// File: rtl/selDivClockEn.sv
module selDivClockEn import selDivPkg::*; #(
  parameter int      REG_W       = 32,
  parameter int      NUM_INPUTS  = 5,
  parameter int      SEL_OFS     = 8,
  parameter int      SEL_W       = 3,
  parameter int      DIV_OFS     = 16,
  parameter int      DIV_W       = 5,
  parameter divModeE DIV_MODE    = DIV_LINEAR,
  parameter int      CONST_RATIO = 3,
  parameter logic [REG_W-1:0] SEL_RST = '0,
  parameter logic [REG_W-1:0] DIV_RST = 32'h0001_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_INPUTS-1:0] srcEn,
  input  logic [REG_W-1:0]      selReg,
  input  logic                  selWrite,
  input  logic [REG_W-1:0]      divReg,
  input  logic                  divWrite,
  output logic                  outEn
);

  localparam int IDX_W = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1;
  localparam int CNT_W = 2 ** DIV_W;

  ctrlStrobesT      strobes;
  logic [IDX_W-1:0] selIdx;
  logic [CNT_W-1:0] term;

  selDivCtrl #(
    .REG_W(REG_W), .NUM_INPUTS(NUM_INPUTS), .SEL_OFS(SEL_OFS), .SEL_W(SEL_W),
    .DIV_OFS(DIV_OFS), .DIV_W(DIV_W), .DIV_MODE(DIV_MODE),
    .CONST_RATIO(CONST_RATIO), .SEL_RST(SEL_RST), .DIV_RST(DIV_RST)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .selReg(selReg), .selWrite(selWrite),
    .divReg(divReg), .divWrite(divWrite), .strobes(strobes),
    .selIdx(selIdx), .term(term)
  );

  selDivPath #(
    .NUM_INPUTS(NUM_INPUTS), .DIV_W(DIV_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .strobes(strobes),
    .selIdx(selIdx), .term(term), .outEn(outEn)
  );

endmodule

// File: tb/tb_selDivClockEn.sv
module tb_selDivClockEn;
  import selDivPkg::*;

  localparam int NIN = 5;
  localparam int SOFS = 8;
  localparam int DOFS = 16;
  localparam int CRATIO = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NIN-1:0] srcEn = '0;
  logic [31:0] selReg = '0, divReg = '0;
  logic selWrite = 1'b0, divWrite = 1'b0;
  logic outLin, outShf, outDbl, outCon;

  always #10 clk = ~clk;

  selDivClockEn #(.DIV_MODE(DIV_LINEAR)) dut (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .selReg(selReg), .selWrite(selWrite),
    .divReg(divReg), .divWrite(divWrite), .outEn(outLin));
  selDivClockEn #(.DIV_MODE(DIV_SHIFT)) dutShf (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .selReg(selReg), .selWrite(selWrite),
    .divReg(divReg), .divWrite(divWrite), .outEn(outShf));
  selDivClockEn #(.DIV_MODE(DIV_DOUBLED)) dutDbl (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .selReg(selReg), .selWrite(selWrite),
    .divReg(divReg), .divWrite(divWrite), .outEn(outDbl));
  selDivClockEn #(.DIV_MODE(DIV_CONST), .CONST_RATIO(CRATIO)) dutCon (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .selReg(selReg), .selWrite(selWrite),
    .divReg(divReg), .divWrite(divWrite), .outEn(outCon));

  int totLin = 0, totShf = 0, totDbl = 0, totCon = 0;
  always @(posedge clk) begin
    if (outLin) totLin <= totLin + 1;
    if (outShf) totShf <= totShf + 1;
    if (outDbl) totDbl <= totDbl + 1;
    if (outCon) totCon <= totCon + 1;
  end

  int nChecks = 0, nFail = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int sel, input int fld);
    @(negedge clk);
    selReg = 32'(sel) << SOFS;
    divReg = 32'(fld) << DOFS;
    selWrite = 1'b1;
    divWrite = 1'b1;
    @(negedge clk);
    selWrite = 1'b0;
    divWrite = 1'b0;
  endtask

  task automatic pulses(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      srcEn[src] = 1'b1;
      @(negedge clk);
      srcEn = '0;
    end
    repeat (3) @(negedge clk);
  endtask

  // {select field, divider field, pulses}
  localparam int VEC [6][3] = '{
    '{0, 0, 5}, '{1, 1, 9}, '{2, 2, 14}, '{3, 3, 17}, '{5, 1, 8}, '{7, 2, 13}
  };

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R1 outEn low in reset", int'(outLin | outShf | outDbl | outCon), 0);
    end
    rstN = 1'b1;

    // R1: default config, source 0, ratio 2
    begin
      int b = totLin;
      pulses(0, 4);
      check("R1 default ratio 2", totLin - b, 2);
    end

    // table walk over all four modes (R2..R5, R7 via sel 5 and 7)
    for (int v = 0; v < 6; v++) begin
      int sel = VEC[v][0];
      int f = VEC[v][1];
      int n = VEC[v][2];
      int src = (sel < NIN) ? sel : 0;
      int bL, bS, bD, bC;
      cfg(sel, f);
      bL = totLin; bS = totShf; bD = totDbl; bC = totCon;
      pulses(src, n);
      check(sel < NIN ? "R2 linear" : "R7 fallback linear", totLin - bL, n / (f + 1));
      check("R3 shift", totShf - bS, n / (1 << f));
      check("R4 doubled", totDbl - bD, n / (2 * (f + 1)));
      check("R5 constant ignores field", totCon - bC, n / CRATIO);
    end

    // R6: unselected source has no effect
    begin
      int b;
      cfg(2, 0);
      b = totLin;
      pulses(1, 3);
      pulses(3, 2);
      check("R6 unselected ignored", totLin - b, 0);
      pulses(2, 2);
      check("R6 selected routed", totLin - b, 2);
    end

    // R7: out-of-range index does not route that index bit
    begin
      int b;
      cfg(6, 0);
      b = totLin;
      pulses(1, 2);
      pulses(4, 2);
      check("R7 fallback excludes others", totLin - b, 0);
      pulses(0, 3);
      check("R7 fallback routes input 0", totLin - b, 3);
    end

    // R8: rewrite mid-count restarts
    begin
      int b;
      cfg(0, 3);
      b = totLin;
      pulses(0, 3);
      cfg(0, 3);
      pulses(0, 3);
      check("R8 no short period after restart", totLin - b, 0);
      pulses(0, 1);
      check("R8 full period after restart", totLin - b, 1);
    end

    // R9: pulse in write cycle discarded
    begin
      int b;
      cfg(0, 0);
      b = totLin;
      @(negedge clk);
      divWrite = 1'b1;
      divReg = 32'(0) << DOFS;
      srcEn[0] = 1'b1;
      @(negedge clk);
      divWrite = 1'b0;
      srcEn = '0;
      repeat (3) @(negedge clk);
      check("R9 write-cycle pulse dropped", totLin - b, 0);
      pulses(0, 1);
      check("R9 next pulse counted", totLin - b, 1);
    end

    // R10: single-cycle output timing, ratio 2
    begin
      cfg(0, 1);
      @(negedge clk); srcEn[0] = 1'b1;
      @(negedge clk); srcEn = '0;
      check("R10 no output after first pulse", int'(outLin), 0);
      @(negedge clk); srcEn[0] = 1'b1;
      @(negedge clk); srcEn = '0;
      check("R10 output after Nth pulse", int'(outLin), 1);
      @(negedge clk);
      check("R10 output one cycle wide", int'(outLin), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule